// File: doc/BRIEF.md
# Multi-Function Logic Control Cell

This block is one configurable logic cell of a programmable logic fabric. Four sum-of-products terms arrive from the logic array (sum A, sum B, sum C, sum D), and static configuration gives each of them a role. A data input feeds a storage element that can behave as a D, T or JK flip-flop. The remaining terms can act as set or clear controls, as the cell clock, as an output enable for the attached pad, or as a buried feedback node. The cell also receives global signals: a shared clock, a shared preset, a shared reset and a run-time register-type switch.

The register-type switch lets a cell configured as D turn into a T or JK cell while the design is running. A loadable counter can then load its value in D form and count in T form, which saves array terms. The cell drives two selectable data outputs, each taking the register value or one of the combinational sums A, B or C. A third output carries sum D, either as the pad output enable or as a feedback node.

The whole cell runs on one system clock. The selected cell clock (global clock, sum C or sum D, with per-cell polarity) is sampled by a small tracking state machine. The register advances in the system cycle where that machine sees a rising level, so no derived clock exists in the block. The tracker has three states: ARM, LO and HI. After reset it sits in ARM. From ARM it goes to LO or HI according to the sampled level, and this first step produces no edge. In every later cycle it moves between LO and HI with the level, and the move LO to HI is the cell edge.

Top module: `lcc_cell`

## Requirements
- R1: In D form, at a cell edge the register takes the value of sum A.
- R2: In T form, at a cell edge the register inverts when sum A is 1 and holds when sum A is 0.
- R3: In JK form (J = sum A, K = sum B), at a cell edge the input pairs behave as follows: 1/1 inverts, 0/0 holds, 1/0 sets and 0/1 clears.
- R4: The base form is coded by `cfg_base_type` as 0 D, 1 T, 2 JK and 3 D. While `cfg_dyn_en` and `glb_type` are both 1, the form becomes T when `cfg_dyn_jk` is 0 and JK when it is 1.
- R5: `cfg_clk_src` picks the cell clock: 1 is sum C, 2 is sum D, and 0 or 3 is `glb_clk`. The register changes only in the system cycle where the selected level is sampled high after having been sampled low. The first sample after reset produces no edge.
- R6: When `cfg_clk_inv` is 1, the selected clock is inverted before edge detection, so a falling level acts as the edge.
- R7: Set is `glb_preset` OR (sum B when `cfg_b_preset` is 1). Clear is `glb_reset` OR (sum C when `cfg_c_reset` is 1). Clear wins when both are active, and either one overrides the data function.
- R8: When `cfg_async` is 1, set and clear act at the next system clock without any cell edge. When `cfg_async` is 0, they act only at a cell edge.
- R9: Data output i is selected by `cfg_out_sel[2i+1:2i]`: 0 gives the register, 1 gives sum A, 2 gives sum B, 3 gives sum C. Sums reach the output combinationally.
- R10: When `cfg_d_oe` is 1, `pad_oe` follows sum D and `fb_out` is 0. When it is 0, `pad_oe` is 1 and `fb_out` follows sum D.
- R11: While `rst_n` is low, the register is 0 and the clock tracker re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_a | input | 1 | Array sum A (D/T/J or combinational) |
| sum_b | input | 1 | Array sum B (K, set or combinational) |
| sum_c | input | 1 | Array sum C (clock, clear or combinational) |
| sum_d | input | 1 | Array sum D (clock, pad enable or feedback) |
| glb_clk | input | 1 | Shared cell clock |
| glb_preset | input | 1 | Shared set control |
| glb_reset | input | 1 | Shared clear control |
| glb_type | input | 1 | Run-time register-type switch |
| cfg_clk_src | input | 2 | Cell clock source select |
| cfg_clk_inv | input | 1 | Cell clock polarity invert |
| cfg_base_type | input | 2 | Base register form |
| cfg_dyn_en | input | 1 | Cell follows the type switch |
| cfg_dyn_jk | input | 1 | Switched form: 0 T, 1 JK |
| cfg_b_preset | input | 1 | Sum B used as set |
| cfg_c_reset | input | 1 | Sum C used as clear |
| cfg_async | input | 1 | Set/clear independent of the cell edge |
| cfg_out_sel | input | 4 | Two 2-bit data output selects |
| cfg_d_oe | input | 1 | Sum D used as pad enable |
| data_out | output | 2 | Selectable data outputs |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Buried feedback from sum D |

## Verification
The assertions check on every cycle the following register rules:
- The register holds between cell edges unless an active asynchronous control is present.
- Clear wins over set.
- An asynchronous set takes effect without a cell edge.
- At a cell edge, the register follows the D load, the T toggle and the JK set rules.

Only the bench's scenarios show the remaining behaviours. These are the mapping from configuration codes to clock source and polarity, the run-time switch between forms, the arming step after reset, and the routing of the sums to the data, enable and feedback outputs. The bench checks them against a behavioural model under directed and random stimulus.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    typedef enum logic [1:0] {
        RT_D  = 2'd0,
        RT_T  = 2'd1,
        RT_JK = 2'd2
    } reg_type_e;

    typedef enum logic [1:0] {
        TRK_ARM = 2'd0,
        TRK_LO  = 2'd1,
        TRK_HI  = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        OSEL_Q = 2'd0,
        OSEL_A = 2'd1,
        OSEL_B = 2'd2,
        OSEL_C = 2'd3
    } osel_e;

    localparam logic [1:0] CSRC_SUMC = 2'd1;
    localparam logic [1:0] CSRC_SUMD = 2'd2;
endpackage

// File: rtl/lcc_clk_track.sv
module lcc_clk_track
    import lcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       glb_clk,
    input  logic       sum_c,
    input  logic       sum_d,
    input  logic [1:0] src,
    input  logic       inv,
    output logic       cell_edge
);
    trk_state_e state_q, state_d;
    logic       lvl;

    always_comb begin
        unique case (src)
            CSRC_SUMC: lvl = sum_c ^ inv;
            CSRC_SUMD: lvl = sum_d ^ inv;
            default:   lvl = glb_clk ^ inv;
        endcase
    end

    always_comb begin
        state_d = lvl ? TRK_HI : TRK_LO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_ARM;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            TRK_LO:  cell_edge = lvl;
            default: cell_edge = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcc_reg_core.sv
module lcc_reg_core
    import lcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cell_edge,
    input  reg_type_e cur_type,
    input  logic      in_a,
    input  logic      in_b,
    input  logic      set_req,
    input  logic      clr_req,
    input  logic      async_mode,
    output logic      q
);
    logic data_next;
    logic q_next;
    logic ctrl_live;

    always_comb begin
        unique case (cur_type)
            RT_T:    data_next = q ^ in_a;
            RT_JK:   data_next = (in_a & ~q) | (~in_b & q);
            default: data_next = in_a;
        endcase
    end

    assign ctrl_live = async_mode | cell_edge;

    always_comb begin
        q_next = q;
        if (ctrl_live && clr_req)      q_next = 1'b0;
        else if (ctrl_live && set_req) q_next = 1'b1;
        else if (cell_edge)            q_next = data_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end
endmodule

// File: rtl/lcc_out_mux.sv
module lcc_out_mux
    import lcc_pkg::*;
#(
    parameter int NUM_OUT = 2,
    localparam int SEL_W  = 2
) (
    input  logic                     q,
    input  logic                     sum_a,
    input  logic                     sum_b,
    input  logic                     sum_c,
    input  logic [NUM_OUT*SEL_W-1:0] sel,
    output logic [NUM_OUT-1:0]       dout
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        osel_e code;
        assign code = osel_e'(sel[i*SEL_W +: SEL_W]);
        always_comb begin
            unique case (code)
                OSEL_A:  dout[i] = sum_a;
                OSEL_B:  dout[i] = sum_b;
                OSEL_C:  dout[i] = sum_c;
                default: dout[i] = q;
            endcase
        end
    end
endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
    import lcc_pkg::*;
#(
    parameter int NUM_OUT = 2,
    localparam int SEL_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sum_a,
    input  logic                     sum_b,
    input  logic                     sum_c,
    input  logic                     sum_d,
    input  logic                     glb_clk,
    input  logic                     glb_preset,
    input  logic                     glb_reset,
    input  logic                     glb_type,
    input  logic [1:0]               cfg_clk_src,
    input  logic                     cfg_clk_inv,
    input  logic [1:0]               cfg_base_type,
    input  logic                     cfg_dyn_en,
    input  logic                     cfg_dyn_jk,
    input  logic                     cfg_b_preset,
    input  logic                     cfg_c_reset,
    input  logic                     cfg_async,
    input  logic [NUM_OUT*SEL_W-1:0] cfg_out_sel,
    input  logic                     cfg_d_oe,
    output logic [NUM_OUT-1:0]       data_out,
    output logic                     pad_oe,
    output logic                     fb_out
);
    logic      cell_edge;
    logic      set_req;
    logic      clr_req;
    logic      q_r;
    reg_type_e cur_type;

    always_comb begin
        if (cfg_dyn_en && glb_type) begin
            cur_type = cfg_dyn_jk ? RT_JK : RT_T;
        end else begin
            unique case (cfg_base_type)
                2'd1:    cur_type = RT_T;
                2'd2:    cur_type = RT_JK;
                default: cur_type = RT_D;
            endcase
        end
    end

    assign set_req = glb_preset | (cfg_b_preset & sum_b);
    assign clr_req = glb_reset  | (cfg_c_reset  & sum_c);

    lcc_clk_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .glb_clk   (glb_clk),
        .sum_c     (sum_c),
        .sum_d     (sum_d),
        .src       (cfg_clk_src),
        .inv       (cfg_clk_inv),
        .cell_edge (cell_edge)
    );

    lcc_reg_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_edge  (cell_edge),
        .cur_type   (cur_type),
        .in_a       (sum_a),
        .in_b       (sum_b),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .async_mode (cfg_async),
        .q          (q_r)
    );

    lcc_out_mux #(.NUM_OUT(NUM_OUT)) u_mux (
        .q     (q_r),
        .sum_a (sum_a),
        .sum_b (sum_b),
        .sum_c (sum_c),
        .sel   (cfg_out_sel),
        .dout  (data_out)
    );

    assign pad_oe = cfg_d_oe ? sum_d : 1'b1;
    assign fb_out = cfg_d_oe ? 1'b0  : sum_d;
endmodule

// File: rtl/lcc_cell_chk.sv
module lcc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cell_edge,
    input logic       async_mode,
    input logic       set_req,
    input logic       clr_req,
    input logic       q,
    input logic       sum_a,
    input logic       sum_b,
    input logic [1:0] cur_type
);
    logic quiet;
    assign quiet = !set_req && !clr_req;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && (async_mode || cell_edge)) |=> !q); // R7

    AST_ASYNC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (async_mode && set_req && !clr_req) |=> q); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cell_edge && !(async_mode && (set_req || clr_req))) |=> $stable(q)); // R5

    AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_edge && quiet && cur_type == 2'd0) |=> (q == $past(sum_a))); // R1

    AST_T_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_edge && quiet && cur_type == 2'd1) |=> (q == ($past(q) ^ $past(sum_a)))); // R2

    AST_JK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_edge && quiet && cur_type == 2'd2 && sum_a && !sum_b) |=> q); // R3
endmodule

bind lcc_cell lcc_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_edge  (cell_edge),
    .async_mode (cfg_async),
    .set_req    (set_req),
    .clr_req    (clr_req),
    .q          (q_r),
    .sum_a      (sum_a),
    .sum_b      (sum_b),
    .cur_type   (cur_type)
);

// File: tb/lcc_cell_tb.sv
`timescale 1ns/1ps
module lcc_cell_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_a = 0, sum_b = 0, sum_c = 0, sum_d = 0;
    logic glb_clk = 0, glb_preset = 0, glb_reset = 0, glb_type = 0;
    logic [1:0] cfg_clk_src = 0, cfg_base_type = 0;
    logic cfg_clk_inv = 0, cfg_dyn_en = 0, cfg_dyn_jk = 0;
    logic cfg_b_preset = 0, cfg_c_reset = 0, cfg_async = 0, cfg_d_oe = 0;
    logic [3:0] cfg_out_sel = 4'b0100;
    logic [1:0] data_out;
    logic pad_oe, fb_out;

    integer checks = 0;
    integer errors = 0;
    integer m_q = 0, m_armed = 0, m_prev = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcc_cell u_dut (
        .clk(clk), .rst_n(rst_n), .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c),
        .sum_d(sum_d), .glb_clk(glb_clk), .glb_preset(glb_preset),
        .glb_reset(glb_reset), .glb_type(glb_type), .cfg_clk_src(cfg_clk_src),
        .cfg_clk_inv(cfg_clk_inv), .cfg_base_type(cfg_base_type),
        .cfg_dyn_en(cfg_dyn_en), .cfg_dyn_jk(cfg_dyn_jk),
        .cfg_b_preset(cfg_b_preset), .cfg_c_reset(cfg_c_reset),
        .cfg_async(cfg_async), .cfg_out_sel(cfg_out_sel), .cfg_d_oe(cfg_d_oe),
        .data_out(data_out), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    function automatic integer pick(input integer code);
        case (code)
            1: pick = sum_a;
            2: pick = sum_b;
            3: pick = sum_c;
            default: pick = m_q;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [3:0] exp_v, act_v;
        exp_v[0] = pick(cfg_out_sel[1:0]);
        exp_v[1] = pick(cfg_out_sel[3:2]);
        exp_v[2] = cfg_d_oe ? sum_d : 1'b1;
        exp_v[3] = cfg_d_oe ? 1'b0 : sum_d;
        act_v = {fb_out, pad_oe, data_out};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (fb,oe,out1,out0)", tag, act_v, exp_v);
        end
    endtask

    // one system cycle: model step from inputs held across the edge, then compare
    task automatic cyc(input string tag);
        integer lvl, edge_v, typ, rq, pq, nq;
        case (cfg_clk_src)
            2'd1: lvl = sum_c;
            2'd2: lvl = sum_d;
            default: lvl = glb_clk;
        endcase
        lvl = lvl ^ cfg_clk_inv;
        edge_v = (m_armed == 1 && m_prev == 0 && lvl == 1) ? 1 : 0;
        if (cfg_dyn_en && glb_type) typ = cfg_dyn_jk ? 2 : 1;
        else typ = (cfg_base_type == 2'd3) ? 0 : cfg_base_type;
        rq = glb_reset | (cfg_c_reset & sum_c);
        pq = glb_preset | (cfg_b_preset & sum_b);
        nq = m_q;
        if (edge_v == 1) begin
            if (typ == 0) nq = sum_a;
            else if (typ == 1) nq = sum_a ? 1 - m_q : m_q;
            else if (sum_a && sum_b) nq = 1 - m_q;
            else if (sum_a) nq = 1;
            else if (sum_b) nq = 0;
        end
        if (cfg_async || edge_v == 1) begin
            if (rq) nq = 0;
            else if (pq) nq = 1;
        end
        if (!rst_n) begin
            nq = 0; m_armed = 0; m_prev = 0;
        end else begin
            m_armed = 1; m_prev = lvl;
        end
        @(posedge clk);
        #2;
        m_q = nq;
        compare(tag);
    endtask

    task automatic gpulse(input string tag);
        glb_clk = 1; cyc(tag);
        glb_clk = 0; cyc(tag);
    endtask

    task automatic defaults();
        sum_a = 0; sum_b = 0; sum_c = 0; sum_d = 0;
        glb_clk = 0; glb_preset = 0; glb_reset = 0; glb_type = 0;
        cfg_clk_src = 0; cfg_clk_inv = 0; cfg_base_type = 0; cfg_dyn_en = 0;
        cfg_dyn_jk = 0; cfg_b_preset = 0; cfg_c_reset = 0; cfg_async = 0;
        cfg_d_oe = 0; cfg_out_sel = 4'b0100;
        cyc("setup");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        sum_a = 1; glb_clk = 1; glb_preset = 1;
        repeat (3) cyc("R11");
        glb_preset = 0; rst_n = 1;
        cyc("R11");
        defaults();

        // R1 D load at global edges; A changes without an edge are held (R5)
        sum_a = 1; gpulse("R1");
        sum_a = 0; gpulse("R1");
        sum_a = 1; gpulse("R1");
        sum_a = 0; cyc("R5"); cyc("R5");

        // R2 T form
        cfg_base_type = 2'd1; sum_a = 1;
        repeat (3) gpulse("R2");
        sum_a = 0; repeat (2) gpulse("R2");

        // R3 JK table
        cfg_base_type = 2'd2;
        sum_a = 1; sum_b = 0; gpulse("R3");
        sum_a = 0; sum_b = 0; gpulse("R3");
        sum_a = 1; sum_b = 1; gpulse("R3");
        sum_a = 0; sum_b = 1; gpulse("R3");
        sum_a = 1; sum_b = 1; gpulse("R3");
        sum_b = 0;

        // R4 run-time type switch
        cfg_base_type = 2'd0; cfg_dyn_en = 1; glb_type = 1; sum_a = 1;
        repeat (3) gpulse("R4");
        glb_type = 0; sum_a = 0; gpulse("R4");
        cfg_dyn_jk = 1; glb_type = 1; sum_a = 1; sum_b = 1;
        repeat (2) gpulse("R4");
        sum_a = 0; gpulse("R4");
        cfg_dyn_en = 0; cfg_base_type = 2'd3; sum_a = 1; sum_b = 0; gpulse("R4");
        glb_type = 0; cfg_dyn_jk = 0;

        // R5 clock source select
        cfg_base_type = 2'd1; sum_a = 1; cfg_clk_src = 2'd1;
        repeat (2) gpulse("R5");
        repeat (2) begin sum_c = 1; cyc("R5"); sum_c = 0; cyc("R5"); end
        cfg_clk_src = 2'd2;
        repeat (2) begin sum_d = 1; cyc("R5"); sum_d = 0; cyc("R5"); end
        cfg_clk_src = 2'd3; gpulse("R5");

        // R6 inverted polarity
        cfg_clk_src = 2'd0; cfg_clk_inv = 1;
        glb_clk = 1; cyc("R6"); cyc("R6");
        glb_clk = 0; cyc("R6"); cyc("R6");
        glb_clk = 1; cyc("R6");
        cfg_clk_inv = 0; glb_clk = 0; cyc("R6");

        // R7 sync set/clear, clear wins
        cfg_base_type = 2'd0; sum_a = 0; glb_preset = 1; cyc("R7");
        gpulse("R7");
        glb_reset = 1; gpulse("R7");
        glb_reset = 0; glb_preset = 0; sum_a = 0; gpulse("R7");
        cfg_b_preset = 1; sum_b = 1; gpulse("R7");
        cfg_c_reset = 1; sum_c = 1; cfg_clk_src = 2'd0; gpulse("R7");
        sum_b = 0; sum_c = 0; cfg_b_preset = 0; cfg_c_reset = 0;

        // R8 async controls act without an edge
        cfg_async = 1; glb_preset = 1; cyc("R8"); cyc("R8");
        glb_reset = 1; cyc("R8");
        glb_reset = 0; glb_preset = 0; cyc("R8");
        cfg_async = 0;

        // R9 output selects
        sum_a = 1; sum_b = 0; sum_c = 1; gpulse("R9");
        for (int s = 0; s < 16; s++) begin
            cfg_out_sel = s[3:0];
            sum_a = s[0]; sum_b = ~s[1]; sum_c = s[2];
            cyc("R9");
        end

        // R10 sum D as enable or feedback
        cfg_d_oe = 1; sum_d = 0; cyc("R10"); sum_d = 1; cyc("R10");
        cfg_d_oe = 0; sum_d = 0; cyc("R10"); sum_d = 1; cyc("R10");

        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 50 == 0) begin
                {cfg_clk_src, cfg_clk_inv, cfg_base_type, cfg_dyn_en, cfg_dyn_jk,
                 cfg_b_preset, cfg_c_reset, cfg_async, cfg_out_sel, cfg_d_oe} = 16'($urandom);
            end
            {sum_a, sum_b, sum_c, sum_d, glb_clk, glb_type} = 6'($urandom);
            glb_preset = ($urandom % 8) == 0;
            glb_reset  = ($urandom % 8) == 0;
            cyc("MIX");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule